// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single internal read or write requests into timed cycles on an external memory and peripheral bus. Each request arrives with its own cycle settings, normally those of the address window chosen upstream. These settings choose a shared address/data bus with an address latch strobe or a separate address bus, an 8-bit or 16-bit data path, and how many address bits are driven. They also set the address-phase, command-phase and hold-off lengths, and whether a ready input of chosen polarity can stretch the command.

An access passes through the states IDLE, ADDR, CMD, RWAIT and HOLD. The transitions are: IDLE->ADDR on a request in shared-bus mode; IDLE->CMD on a request in separate-bus mode; ADDR->CMD when the address phase ends; CMD->RWAIT when the command length has elapsed and ready is not active; CMD->HOLD or RWAIT->HOLD when the command ends and a hold-off is set; HOLD->ADDR or HOLD->CMD for the second byte of a split access; and CMD, RWAIT or HOLD->IDLE when the last beat finishes. The same beat and finish transitions are taken directly from CMD or RWAIT when the hold-off is zero. All outputs come from registers updated on the rising clock edge.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset rd_n and wr_n are 1, while ale, ad_oe, done, ad_out, addr_lo, addr_hi and rd_data are 0.
- R2: With cfg_mux=1 an access (or each beat) starts with cfg_ale_len+1 clocks of ale=1, during which ad_oe=1 and ad_out carries the low 16 address bits; ale is never high while rd_n or wr_n is low.
- R3: With cfg_mux=0 ale stays 0, the low 16 address bits are held on addr_lo for the whole access, and addr_lo is 0 in shared-bus mode.
- R4: Each beat holds rd_n (read) or wr_n (write) low for cfg_cmd_len+1 clocks when ready is not used; rd_n and wr_n are never low together.
- R5: After the command, cfg_hold_len clocks (0 to 3) pass with all strobes inactive. Then done is 1 for exactly one clock, in the first IDLE cycle, so that cycle count from the accepting edge to done equals the sum of all phase lengths plus one.
- R6: Address bit i is driven as 0 on addr_hi, addr_lo and on ad_out during the address phase whenever i >= cfg_abits (0 to 24); addr_hi carries bits 23:16.
- R7: With cfg_bus8=1 and req_wide=1 the access is split into two beats at addresses A and A+1 (24-bit wrap), with the low data byte first. Only ad_out[7:0] carries data (ad_out[15:8]=0), and read bytes are taken from ad_in[7:0] into rd_data[7:0] then rd_data[15:8].
- R8: With cfg_bus8=0, a wide request moves all 16 bits in one beat; a byte request (req_wide=0) uses ad_out[7:0] with ad_out[15:8]=0 and returns rd_data={8'h00, ad_in[7:0]}.
- R9: With cfg_rdy_en=1 the command ends at the first rising edge, at or after cfg_cmd_len+1 command clocks, at which rdy_in equals cfg_rdy_pol; with cfg_rdy_en=0 rdy_in has no effect.
- R10: Read data is captured at the edge where the command ends, is valid when done is 1, and stays unchanged until the next request is accepted; a write leaves rd_data at 0.
- R11: All request and configuration inputs are sampled on the accepting edge; changing them during an access does not change it.
- R12: A request is accepted only in IDLE, including the cycle in which done is 1, so back-to-back accesses have no idle gap; requests while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all bus timing follows its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken in IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit request, 0 = byte request |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| cfg_mux | input | 1 | 1 = shared address/data bus with ale |
| cfg_bus8 | input | 1 | 1 = 8-bit data path |
| cfg_ale_len | input | 2 | Address phase length minus one |
| cfg_cmd_len | input | 3 | Command phase length minus one |
| cfg_hold_len | input | 2 | Hold-off length in clocks |
| cfg_rdy_en | input | 1 | Enable ready stretching |
| cfg_rdy_pol | input | 1 | Active level of rdy_in |
| cfg_abits | input | 5 | Number of driven address bits, 0 to 24 |
| rdy_in | input | 1 | Ready from the device |
| ad_in | input | 16 | Data read from the bus |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 16 | Address (ADDR phase) or write data |
| ad_oe | output | 1 | Output enable for ad_out |
| addr_lo | output | 16 | Separate low address bus |
| addr_hi | output | 8 | Upper address bits |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Read result |

## Verification
The completion pulse of one access and the acceptance of the next can fall in the same cycle, since done is raised in the first IDLE cycle where a new request is also taken. The bench keeps req_valid high across a whole access. It then checks that the clock after done already shows the address strobe of the second access, that the second access completes with its own timing, and that no third access follows once the request is dropped. A second overlap, ready arriving in the very cycle the programmed command length expires, is provoked by setting the ready delay equal to the command length and is judged by the strobe-low count.

// File: rtl/ebs_pkg.sv
`timescale 1ns/1ps
package ebs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_RWAIT,
        ST_HOLD
    } ebs_state_e;

    typedef struct packed {
        logic       mux;
        logic       bus8;
        logic [1:0] ale_len;
        logic [2:0] cmd_len;
        logic [1:0] hold_len;
        logic       rdy_en;
        logic       rdy_pol;
    } ebs_timing_t;
endpackage

// File: rtl/ebs_phase_cnt.sv
`timescale 1ns/1ps
module ebs_phase_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/ebs_addr_mask.sv
`timescale 1ns/1ps
module ebs_addr_mask #(
    parameter int AW  = 24,
    parameter int ABW = 5
) (
    input  logic [AW-1:0]  addr,
    input  logic [ABW-1:0] nbits,
    output logic [AW-1:0]  masked
);
    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign masked[i] = addr[i] & (nbits > ABW'(i));
    end
endmodule

// File: rtl/ebs_data_lane.sv
`timescale 1ns/1ps
module ebs_data_lane #(
    parameter int DW = 16
) (
    input  logic          bus8,
    input  logic          wide,
    input  logic          beat,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ad_in,
    input  logic [DW-1:0] rd_cur,
    output logic [DW-1:0] lane_out,
    output logic [DW-1:0] rd_next
);
    localparam int HW = DW / 2;

    always_comb begin
        if (bus8) begin
            lane_out = {{HW{1'b0}}, beat ? wdata[DW-1:HW] : wdata[HW-1:0]};
            rd_next  = beat ? {ad_in[HW-1:0], rd_cur[HW-1:0]}
                            : {rd_cur[DW-1:HW], ad_in[HW-1:0]};
        end else begin
            lane_out = wide ? wdata : {{HW{1'b0}}, wdata[HW-1:0]};
            rd_next  = wide ? ad_in : {{HW{1'b0}}, ad_in[HW-1:0]};
        end
    end
endmodule

// File: rtl/ext_bus_seq.sv
`timescale 1ns/1ps
module ext_bus_seq #(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic                       req_wide,
    input  logic [AW-1:0]              req_addr,
    input  logic [DW-1:0]              req_wdata,
    input  logic                       cfg_mux,
    input  logic                       cfg_bus8,
    input  logic [1:0]                 cfg_ale_len,
    input  logic [2:0]                 cfg_cmd_len,
    input  logic [1:0]                 cfg_hold_len,
    input  logic                       cfg_rdy_en,
    input  logic                       cfg_rdy_pol,
    input  logic [$clog2(AW+1)-1:0]    cfg_abits,
    input  logic                       rdy_in,
    input  logic [DW-1:0]              ad_in,
    output logic                       ale,
    output logic                       rd_n,
    output logic                       wr_n,
    output logic [DW-1:0]              ad_out,
    output logic                       ad_oe,
    output logic [DW-1:0]              addr_lo,
    output logic [AW-DW-1:0]           addr_hi,
    output logic                       done,
    output logic [DW-1:0]              rd_data
);
    import ebs_pkg::*;

    localparam int ABW = $clog2(AW + 1);
    localparam int CW  = 3;

    ebs_state_e        state_q, state_d;
    ebs_timing_t       tim_q;
    logic [ABW-1:0]    abits_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    logic              wr_q, wide_q, beat_q, split_q;

    logic              ld;
    logic [CW-1:0]     ldv;
    logic              last, start, cmd_end, fin, more;
    logic              rdy_ok;
    logic [AW-1:0]     beat_addr, maddr;
    logic [DW-1:0]     lane_out, rd_next;

    ebs_phase_cnt #(.W(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ldv), .last(last)
    );

    assign beat_addr = addr_q + AW'(beat_q);

    ebs_addr_mask #(.AW(AW), .ABW(ABW)) u_mask (
        .addr(beat_addr), .nbits(abits_q), .masked(maddr)
    );

    ebs_data_lane #(.DW(DW)) u_lane (
        .bus8(tim_q.bus8), .wide(wide_q), .beat(beat_q), .wdata(wdata_q),
        .ad_in(ad_in), .rd_cur(rd_data), .lane_out(lane_out), .rd_next(rd_next)
    );

    assign rdy_ok = !tim_q.rdy_en || (rdy_in == tim_q.rdy_pol);
    assign more   = split_q && !beat_q;

    // Next-state and phase-counter load
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ldv     = '0;
        start   = 1'b0;
        cmd_end = 1'b0;
        fin     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    start = 1'b1;
                    ld    = 1'b1;
                    if (cfg_mux) begin
                        state_d = ST_ADDR;
                        ldv     = {1'b0, cfg_ale_len};
                    end else begin
                        state_d = ST_CMD;
                        ldv     = cfg_cmd_len;
                    end
                end
            end
            ST_ADDR: begin
                if (last) begin
                    state_d = ST_CMD;
                    ld      = 1'b1;
                    ldv     = tim_q.cmd_len;
                end
            end
            ST_CMD: begin
                if (last) begin
                    if (rdy_ok) cmd_end = 1'b1;
                    else        state_d = ST_RWAIT;
                end
            end
            ST_RWAIT: begin
                if (rdy_ok) cmd_end = 1'b1;
            end
            ST_HOLD: begin
                if (last) fin = 1'b1;
            end
        endcase
        if (cmd_end) begin
            if (tim_q.hold_len != 2'd0) begin
                state_d = ST_HOLD;
                ld      = 1'b1;
                ldv     = {1'b0, tim_q.hold_len} - 3'd1;
            end else begin
                fin = 1'b1;
            end
        end
        if (fin) begin
            if (more) begin
                ld = 1'b1;
                if (tim_q.mux) begin
                    state_d = ST_ADDR;
                    ldv     = {1'b0, tim_q.ale_len};
                end else begin
                    state_d = ST_CMD;
                    ldv     = tim_q.cmd_len;
                end
            end else begin
                state_d = ST_IDLE;
            end
        end
    end

    // State register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tim_q   <= '0;
            abits_q <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            wide_q  <= 1'b0;
            beat_q  <= 1'b0;
            split_q <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            state_q <= state_d;
            done    <= fin && !more;
            if (start) begin
                tim_q   <= '{mux: cfg_mux, bus8: cfg_bus8, ale_len: cfg_ale_len,
                             cmd_len: cfg_cmd_len, hold_len: cfg_hold_len,
                             rdy_en: cfg_rdy_en, rdy_pol: cfg_rdy_pol};
                abits_q <= cfg_abits;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                wr_q    <= req_write;
                wide_q  <= req_wide;
                beat_q  <= 1'b0;
                split_q <= req_wide && cfg_bus8;
                rd_data <= '0;
            end
            if (cmd_end && !wr_q)
                rd_data <= rd_next;
            if (fin && more)
                beat_q <= 1'b1;
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        logic strobe;
        strobe  = (state_q == ST_CMD) || (state_q == ST_RWAIT);
        ale     = (state_q == ST_ADDR);
        rd_n    = !(strobe && !wr_q);
        wr_n    = !(strobe && wr_q);
        ad_oe   = ale || (strobe && wr_q);
        ad_out  = ale ? maddr[DW-1:0] : ((strobe && wr_q) ? lane_out : '0);
        addr_lo = ((state_q != ST_IDLE) && !tim_q.mux) ? maddr[DW-1:0] : '0;
        addr_hi = (state_q != ST_IDLE) ? maddr[AW-1:DW] : '0;
    end
endmodule

// File: rtl/ext_bus_seq_checker.sv
`timescale 1ns/1ps
module ext_bus_seq_checker #(
    parameter int AW  = 24,
    parameter int DW  = 16,
    parameter int ABW = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ale,
    input logic             rd_n,
    input logic             wr_n,
    input logic             done,
    input logic [DW-1:0]    addr_lo,
    input logic [AW-DW-1:0] addr_hi,
    input logic             mux_q,
    input logic [ABW-1:0]   abits_q
);
    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    a_r2_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

    a_r3_lo_quiet_in_mux: assert property (@(posedge clk) disable iff (!rst_n)
        mux_q |-> (addr_lo == '0));

    a_r6_width_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (({addr_hi, addr_lo} >> abits_q) == '0));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_n && wr_n && !ale));
endmodule

bind ext_bus_seq ext_bus_seq_checker #(.AW(AW), .DW(DW), .ABW($clog2(AW+1))) u_chk (
    .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .done(done),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .mux_q(tim_q.mux), .abits_q(abits_q)
);

// File: tb/ext_bus_seq_test.sv
`timescale 1ns/1ps
module ext_bus_seq_test;
    typedef struct packed {
        bit        mux;
        bit        bus8;
        bit        wide;
        bit        wr;
        bit [1:0]  ale;
        bit [2:0]  cmd;
        bit [1:0]  hold;
        bit [4:0]  abits;
        bit [23:0] addr;
        bit [15:0] wd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 3'd2, 2'd1, 5'd24, 24'h123456, 16'h0000},
        '{1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 3'd0, 2'd0, 5'd24, 24'h001000, 16'hBEEF},
        '{1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 3'd1, 2'd2, 5'd24, 24'h0A00FF, 16'h0000},
        '{1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 3'd3, 2'd0, 5'd16, 24'hFF2468, 16'h5AA5},
        '{1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd7, 2'd3, 5'd20, 24'hABCDEF, 16'h0000},
        '{1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 3'd0, 2'd1, 5'd12, 24'h765432, 16'h1234},
        '{1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 2'd0, 5'd0,  24'h123457, 16'h0000},
        '{1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 3'd0, 2'd0, 5'd24, 24'h000010, 16'h0000}
    };

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, req_wide = 0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic cfg_mux = 0, cfg_bus8 = 0, cfg_rdy_en = 0, cfg_rdy_pol = 0;
    logic [1:0] cfg_ale_len = '0, cfg_hold_len = '0;
    logic [2:0] cfg_cmd_len = '0;
    logic [4:0] cfg_abits = '0;
    logic rdy_in = 1;
    logic [15:0] ad_in;
    logic ale, rd_n, wr_n, ad_oe, done;
    logic [15:0] ad_out, addr_lo, rd_data;
    logic [7:0] addr_hi;

    int nchk = 0, nfail = 0;

    ext_bus_seq uut (.*);

    always #2 clk = ~clk;

    // Device model
    logic        cur_mux = 0;
    logic [23:0] lat = '0, dev_addr, first_da = '0;
    logic        got_first = 0;
    logic [15:0] wcap [2];
    int          ale_cnt = 0, stb_cnt = 0, stb_run = 0, rdy_k = 0;
    logic        rdy_use = 0, rdy_lvl = 0;

    function automatic logic [7:0] mbyte(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    function automatic logic [23:0] amask(logic [23:0] a, int nb);
        return (nb >= 24) ? a : (a & ((24'd1 << nb) - 24'd1));
    endfunction

    always_comb begin
        dev_addr = cur_mux ? lat : {addr_hi, addr_lo};
        ad_in    = {~mbyte(dev_addr), mbyte(dev_addr)};
    end

    always @(negedge clk) begin
        if (ale) begin
            lat = {addr_hi, ad_out};
            ale_cnt++;
        end
        if (!rd_n || !wr_n) begin
            stb_cnt++;
            stb_run++;
            if (!got_first) begin got_first = 1; first_da = dev_addr; end
            if (!wr_n) wcap[dev_addr[0]] = ad_out;
        end else begin
            stb_run = 0;
        end
        rdy_in = rdy_use ? ((stb_run >= rdy_k) ? rdy_lvl : ~rdy_lvl) : ~rdy_lvl;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(vec_t v, bit ren, bit pol);
        cfg_mux = v.mux; cfg_bus8 = v.bus8; cfg_ale_len = v.ale;
        cfg_cmd_len = v.cmd; cfg_hold_len = v.hold; cfg_abits = v.abits;
        cfg_rdy_en = ren; cfg_rdy_pol = pol;
        req_write = v.wr; req_wide = v.wide; req_addr = v.addr; req_wdata = v.wd;
    endtask

    // One access with full checks; scramble changes inputs after acceptance
    task automatic run(vec_t v, bit ren, bit pol, int k, bit scramble);
        int n, beats, nale, stbe, a0, a1;
        logic [15:0] exp_rd;
        @(negedge clk);
        apply(v, ren, pol);
        cur_mux = v.mux; rdy_use = ren; rdy_lvl = pol; rdy_k = k;
        ale_cnt = 0; stb_cnt = 0; got_first = 0;
        wcap[0] = '0; wcap[1] = '0;
        req_valid = 1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                req_valid = 0;
                if (scramble) begin
                    cfg_mux = ~v.mux; cfg_bus8 = ~v.bus8; cfg_cmd_len = 3'd7;
                    cfg_hold_len = 2'd3; cfg_abits = 5'd0; req_write = ~v.wr;
                    req_addr = 24'h000000; cfg_rdy_en = 1'b1;
                end
            end
        end while (!done && n < 200);
        beats = (v.bus8 && v.wide) ? 2 : 1;
        nale  = v.mux ? v.ale + 1 : 0;
        stbe  = (ren && k > v.cmd + 1) ? k : v.cmd + 1;
        chk(scramble ? "R11 cycles" : (ren ? "R9 cycles" : "R5 cycles"),
            n, beats * (nale + stbe + v.hold) + 1);
        chk(v.mux ? "R2 ale clocks" : "R3 no ale", ale_cnt, beats * nale);
        chk(ren ? "R9 strobe clocks" : "R4 strobe clocks", stb_cnt, beats * stbe);
        a0 = amask(v.addr, v.abits);
        a1 = amask(v.addr + 24'd1, v.abits);
        chk("R6 address", first_da, a0);
        if (v.wr) begin
            if (v.bus8 && v.wide) begin
                chk("R7 write low byte", wcap[a0 & 1], {8'h00, v.wd[7:0]});
                chk("R7 write high byte", wcap[a1 & 1], {8'h00, v.wd[15:8]});
            end else if (v.wide) begin
                chk("R8 write word", wcap[a0 & 1], v.wd);
            end else begin
                chk("R8 write byte", wcap[a0 & 1], {8'h00, v.wd[7:0]});
            end
            chk("R10 write leaves rd_data", rd_data, 16'h0000);
        end else begin
            if (v.bus8 && v.wide)
                exp_rd = {mbyte(a1), mbyte(a0)};
            else if (v.wide)
                exp_rd = {~mbyte(a0), mbyte(a0)};
            else
                exp_rd = {8'h00, mbyte(a0)};
            chk(v.bus8 ? "R7 R10 read data" : "R8 R10 read data", rd_data, exp_rd);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        vec_t rv;
        logic [15:0] held;
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rd_n", rd_n, 1); chk("R1 wr_n", wr_n, 1);
        chk("R1 ale", ale, 0);   chk("R1 ad_oe", ad_oe, 0);
        chk("R1 done", done, 0); chk("R1 rd_data", rd_data, 0);
        chk("R1 address", {addr_hi, addr_lo, ad_out}, 0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) run(VECS[i], 0, 0, 0, 0);

        // R10 read data held in idle
        held = rd_data;
        repeat (4) @(negedge clk);
        chk("R10 rd_data held", rd_data, held);

        // R9 ready stretching, both polarities, and disabled
        rv = '{1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd1, 2'd1, 5'd24, 24'h003300, 16'h0};
        run(rv, 1, 0, 5, 0);
        run(rv, 1, 1, 4, 0);
        run(rv, 1, 1, 2, 0);
        run(rv, 0, 0, 6, 0);

        // R11 inputs changed during the access
        run(VECS[0], 0, 0, 0, 1);
        run(VECS[3], 0, 0, 0, 1);

        // R12 back-to-back: request held through the done cycle
        @(negedge clk);
        apply(VECS[5], 0, 0);
        cur_mux = 1; rdy_use = 0;
        req_valid = 1;
        n = 0;
        do begin @(negedge clk); n++; end while (!done && n < 200);
        chk("R12 first done", n, 3 + 1 + 1 + 1);
        @(negedge clk);
        chk("R12 next access without gap", ale, 1);
        req_valid = 0;
        n = 1;
        do begin @(negedge clk); n++; end while (!done && n < 200);
        chk("R12 second done", n, 6);
        @(negedge clk);
        chk("R12 no extra access", {ale, rd_n, wr_n, done}, 4'b0110);

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule